// File: doc/BRIEF.md
# XOR-Label Permutation Network for Bit-Level Trellis Recursion

This block moves the state metrics of a bit-level trellis along the branches for code bit 1. The trellis has M = 2^P states, where P is the number of parity checks. Between two steps, the bit-1 branch joins state label l to state label l XOR h. Here h is the parity-check column for the current step. The network takes all M metric words at once, together with the P-bit column, and returns them reordered. Output slot l then holds the metric that arrived on slot l XOR h. The next add-compare-select stage can then pair every bit-0 metric (unpermuted) with its bit-1 partner (permuted) index for index.

The network is purely combinational and has exactly P columns of 2x2 exchange cells. Each cell either passes its pair through or swaps it. Every cell in column s is steered by bit s of the column vector, with no decoding in between. The first column handles neighbouring pairs. Each later column merges two half-size sub-networks through a fixed cross wiring. A fixed unshuffle of the slot indices at the end restores natural label order. The parameter P sets the number of states and W sets the width of a metric word.

Top module: `parity_banyan_router`

## Requirements
- R1: Word l (0 <= l < 2^P) occupies bits [l*W +: W] of both `words_in` and `words_out`. Bit b of `ctrl` is the coefficient of 2^b in the XOR mask.
- R2: For every value h of `ctrl` and every l, `words_out` word l equals `words_in` word (l XOR h).
- R3: When `ctrl` is all zeros, `words_out` equals `words_in` exactly.
- R4: When only bit b of `ctrl` is set, each pair of words whose indices differ only in bit b trades places, and no other word moves.
- R5: The block has no storage. A change on `words_in` or `ctrl` appears on `words_out` with no clock edge in between.
- R6: Words pass through unmodified in every bit position, including all-ones, all-zeros and single-bit patterns. No value is created or lost: the XOR of all output words equals the XOR of all input words.
- R7: The mapping of R2 holds for every state count the parameter allows, including P = 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl | input | P | Current parity-check column; bit s steers exchange column s |
| words_in | input | W*2^P | Metric words in label order, word l at [l*W +: W] |
| words_out | output | W*2^P | Metric words permuted so that slot l carries input slot l XOR ctrl |

## Verification
The checks on the output mapping assume that `ctrl` and `words_in` are settled, two-valued levels when they are evaluated. They are evaluated inside combinational processes, so transient mixtures during a single input update are not meant to be judged. The bench keeps within this by changing inputs only at one instant and sampling a nanosecond later, never at the same moment as a change. It uses distinct word values in the exhaustive sweeps, so that a misrouted word cannot match its expected value by coincidence. Repeated values appear only in the data-pattern test, where bit transparency rather than routing is the subject.

// File: rtl/banyan_pkg.sv
package banyan_pkg;
  timeunit 1ns; timeprecision 1ps;

  // Rotate the low w bits of v left by one position.
  function automatic int rotl_bits(input int v, input int w);
    if (w <= 1) return v;
    return ((v << 1) | (v >> (w - 1))) & ((1 << w) - 1);
  endfunction

  // For a merge column working on blocks of 2^lvl_log slots, return the
  // sub-network output slot that feeds cell input k within the block.
  function automatic int level_src(input int k, input int lvl_log);
    int q;
    int t;
    q = k >> 1;
    t = k & 1;
    return t * (1 << (lvl_log - 1)) + rotl_bits(q, lvl_log - 1);
  endfunction
endpackage

// File: rtl/banyan_switch.sv
module banyan_switch #(
  parameter int W = 8
) (
  input  logic         swap,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y0,
  output logic [W-1:0] y1
);
  timeunit 1ns; timeprecision 1ps;

  always_comb begin
    y0 = swap ? b : a;
    y1 = swap ? a : b;
  end
endmodule

// File: rtl/banyan_level.sv
module banyan_level #(
  parameter int W   = 8,
  parameter int P   = 3,
  parameter int LVL = 0
) (
  input  logic                sel,
  input  logic [(W<<P)-1:0]   din,
  output logic [(W<<P)-1:0]   dout
);
  timeunit 1ns; timeprecision 1ps;
  import banyan_pkg::*;

  localparam int M  = 1 << P;
  localparam int LG = LVL + 1;
  localparam int BS = 1 << LG;
  localparam int NB = M / BS;

  logic [W-1:0] wired [M];

  // Cross wiring between the two half-size sub-networks of each block.
  for (genvar b = 0; b < NB; b++) begin : g_blk
    for (genvar k = 0; k < BS; k++) begin : g_slot
      localparam int SRC = level_src(k, LG);
      assign wired[b*BS + k] = din[(b*BS + SRC)*W +: W];
    end
  end

  // One column of exchange cells, all steered by the same column bit.
  for (genvar j = 0; j < M/2; j++) begin : g_cell
    banyan_switch #(.W(W)) u_sw (
      .swap (sel),
      .a    (wired[2*j]),
      .b    (wired[2*j+1]),
      .y0   (dout[(2*j)*W +: W]),
      .y1   (dout[(2*j+1)*W +: W])
    );
  end

  logic [W-1:0] xin, xout;
  always_comb begin
    xin  = '0;
    xout = '0;
    for (int i = 0; i < M; i++) begin
      xin  = xin  ^ din[i*W +: W];
      xout = xout ^ dout[i*W +: W];
    end
  end

  always_comb begin
    AST_LEVEL_CONSERVE: assert (xin == xout) // R6
      else $error("level %0d lost or altered a word", LVL);
  end
endmodule

// File: rtl/parity_banyan_router.sv
module parity_banyan_router #(
  parameter int P = 4,
  parameter int W = 8
) (
  input  logic [P-1:0]        ctrl,
  input  logic [(W<<P)-1:0]   words_in,
  output logic [(W<<P)-1:0]   words_out
);
  timeunit 1ns; timeprecision 1ps;
  import banyan_pkg::*;

  localparam int M  = 1 << P;
  localparam int VW = W * M;

  logic [VW-1:0] chain [P+1];

  assign chain[0] = words_in;

  // Column s is steered directly by column bit s.
  for (genvar s = 0; s < P; s++) begin : g_lvl
    banyan_level #(.W(W), .P(P), .LVL(s)) u_lvl (
      .sel  (ctrl[s]),
      .din  (chain[s]),
      .dout (chain[s+1])
    );
  end

  // Final unshuffle back to natural label order.
  for (genvar l = 0; l < M; l++) begin : g_out
    localparam int SRC = rotl_bits(l, P);
    assign words_out[l*W +: W] = chain[P][SRC*W +: W];
  end

  logic [W-1:0] xlast, xfinal;
  always_comb begin
    xlast  = '0;
    xfinal = '0;
    for (int i = 0; i < M; i++) begin
      xlast  = xlast  ^ chain[P][i*W +: W];
      xfinal = xfinal ^ words_out[i*W +: W];
    end
  end

  always_comb begin
    AST_UNSHUFFLE_CONSERVE: assert (xlast == xfinal) // R6
      else $error("unshuffle altered the word set");
  end

  always_comb begin
    for (int l = 0; l < M; l++) begin
      AST_XOR_ROUTE: assert (words_out[l*W +: W] == words_in[(l ^ int'(ctrl))*W +: W]) // R2
        else $error("slot %0d not fed from slot %0d", l, l ^ int'(ctrl));
    end
  end

  always_comb begin
    if (ctrl == '0) begin
      AST_ZERO_IDENTITY: assert (words_out == words_in) // R3
        else $error("zero column is not the identity");
    end
  end

  always_comb begin
    if ($countones(ctrl) == 1) begin
      for (int l = 0; l < M; l++) begin
        AST_SINGLE_BIT_PAIR: assert (words_out[(l ^ int'(ctrl))*W +: W] == words_in[l*W +: W]) // R4
          else $error("pair exchange wrong at slot %0d", l);
      end
    end
  end
endmodule

// File: tb/parity_banyan_router_test.sv
module parity_banyan_router_test;
  timeunit 1ns; timeprecision 1ps;

  localparam int W  = 8;
  localparam int MX = 16 * W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic rst;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  logic [1:0]      h2;
  logic [4*W-1:0]  in2, out2;
  logic [2:0]      h3;
  logic [8*W-1:0]  in3, out3;
  logic [3:0]      h4;
  logic [16*W-1:0] in4, out4;

  parity_banyan_router #(.P(3), .W(W)) uut (
    .ctrl(h3), .words_in(in3), .words_out(out3));
  parity_banyan_router #(.P(2), .W(W)) uut_p2 (
    .ctrl(h2), .words_in(in2), .words_out(out2));
  parity_banyan_router #(.P(4), .W(W)) uut_p4 (
    .ctrl(h4), .words_in(in4), .words_out(out4));

  function automatic logic [MX-1:0] make_words(input int seed);
    logic [MX-1:0] v;
    for (int l = 0; l < 16; l++) v[l*W +: W] = 8'(l * 29 + seed);
    return v;
  endfunction

  task automatic drive(input int p, input logic [MX-1:0] w, input int h);
    case (p)
      2: begin in2 = w[4*W-1:0]; h2 = 2'(h); end
      3: begin in3 = w[8*W-1:0]; h3 = 3'(h); end
      default: begin in4 = w; h4 = 4'(h); end
    endcase
  endtask

  // Waits 1 ns after the last input change, then compares every slot.
  task automatic check_all(input int p, input int h, input string req);
    logic [MX-1:0] src, got;
    #1;
    src = '0; got = '0;
    case (p)
      2: begin src[4*W-1:0] = in2; got[4*W-1:0] = out2; end
      3: begin src[8*W-1:0] = in3; got[8*W-1:0] = out3; end
      default: begin src = in4; got = out4; end
    endcase
    for (int l = 0; l < (1 << p); l++) begin
      n_cmp++;
      if (got[l*W +: W] !== src[(l ^ h)*W +: W]) begin
        n_bad++;
        $display("FAIL %s P=%0d h=%0d slot %0d actual %h expected %h",
                 req, p, h, l, got[l*W +: W], src[(l ^ h)*W +: W]);
      end
    end
  endtask

  task automatic t_start_identity();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int p = 2; p <= 4; p++) begin
      drive(p, make_words(7), 0);
      check_all(p, 0, "R3");
    end
  endtask

  task automatic t_packing();
    logic [MX-1:0] w;
    @(negedge clk);
    w = make_words(1);
    drive(2, w, 1);
    #1;
    n_cmp++;
    if (out2[W-1:0] !== w[2*W-1:W]) begin   // R1: slot 0 sits in the low bits
      n_bad++;
      $display("FAIL R1 low word actual %h expected %h", out2[W-1:0], w[2*W-1:W]);
    end
  endtask

  task automatic t_sweep();
    for (int p = 2; p <= 4; p++) begin
      for (int h = 0; h < (1 << p); h++) begin
        @(negedge clk);
        drive(p, make_words(h * 3 + p), h);
        check_all(p, h, "R2/R7");
      end
    end
  endtask

  task automatic t_single_bit();
    for (int p = 2; p <= 4; p++) begin
      for (int b = 0; b < p; b++) begin
        @(negedge clk);
        drive(p, make_words(40 + b), 1 << b);
        check_all(p, 1 << b, "R4");
      end
    end
  endtask

  task automatic t_data_patterns();
    logic [MX-1:0] w;
    for (int l = 0; l < 16; l++) begin
      case (l % 4)
        0: w[l*W +: W] = 8'hFF;
        1: w[l*W +: W] = 8'h00;
        2: w[l*W +: W] = 8'h80;
        default: w[l*W +: W] = 8'(1 << (l % 8));
      endcase
    end
    for (int p = 2; p <= 4; p++) begin
      @(negedge clk);
      drive(p, w, (1 << p) - 1);
      check_all(p, (1 << p) - 1, "R6");
      @(negedge clk);
      drive(p, ~w, 1);
      check_all(p, 1, "R6");
    end
  endtask

  task automatic t_no_clock();
    @(posedge clk);
    #0.5;
    drive(3, make_words(90), 5);
    check_all(3, 5, "R5");          // sampled at +1.5 ns, before the next edge
    drive(3, make_words(91), 2);
    check_all(3, 2, "R5");
  endtask

  initial begin
    rst = 1'b1;
    h2 = '0; h3 = '0; h4 = '0;
    in2 = '0; in3 = '0; in4 = '0;
    t_start_identity();
    t_packing();
    t_sweep();
    t_single_bit();
    t_data_patterns();
    t_no_clock();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2 actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule